// File: doc/BRIEF.md
# LED Fade-Out Driver

This block drives a single LED pin so that a brief event becomes a visible flash which then dims smoothly to dark. A short pulse on the trigger input, of any width and with no timing relation to the clock, sets an internal brightness level to its largest value. A free-running reference counter is compared against that level to produce a pulse-width-modulated pin. The duty cycle of the pin follows the level.

Each time the reference counter rolls over, the level drops by a fixed binary fraction of itself. The fraction is the level shifted right by a parameter amount. The result is an exponential fade built from one shifter and one subtractor, with no multiplier. Once the level is too small for the shifted term to be non-zero, the level falls by one per roll-over, so the LED always ends fully dark. The current level is also presented as an output so that neighbouring logic can observe the fade.

Top module: `led_fade_dimmer`

## Requirements
- R1: `led_o` is registered. It is high in the cycle after a clock edge at which `level_o` was strictly greater than the reference counter. A level of zero never lights the pin. A level of all ones lights it in every cycle except one per counter period.
- R2: When the level is at least 2^`FRAC_SH`, each counter roll-over replaces level L with L - (L >> `FRAC_SH`). With `CNT_W`=8 and `FRAC_SH`=5, a full level of 255 becomes 248 at the first roll-over.
- R3: A rising edge on `trig_i` loads the level with all ones. The edge passes through a two-flop synchroniser and an edge detector. If `trig_i` is first driven high between two clock edges, `level_o` shows all ones after the third clock edge that follows.
- R4: Holding `trig_i` high reloads the level only once. While the input stays high, the fade continues. A further reload needs the input to go low and then high again.
- R5: When the level is non-zero and below 2^`FRAC_SH`, each roll-over lowers it by exactly one. At zero it stays at zero, and the pin stays dark.
- R6: If a trigger edge and a counter roll-over fall in the same cycle, the reload wins, and the level becomes all ones.
- R7: During reset and after it, the level is zero and `led_o` is low.
- R8: The reference counter and the level are both `CNT_W` bits wide (default 24). The counter starts at zero after reset, advances by one every cycle, and rolls over from all ones to zero, so the PWM period is 2^`CNT_W` cycles.
- R9: Between roll-overs, and with no trigger edge, the level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Flash request, any width, asynchronous to `clk` |
| led_o | output | 1 | PWM drive for the LED pin |
| level_o | output | CNT_W | Current brightness level |

## Verification
The assertions check several rules on every cycle:
- a reload always yields all ones, and the synchronised trigger edge lasts one cycle;
- the level never rises except on a reload, and holds between roll-overs;
- at a roll-over the level strictly falls whenever it is non-zero;
- a zero level keeps the pin dark.

Only the bench scenarios can show the exact values and orderings. These are the 255-to-248 step, the three-edge reload latency, the single reload under a held trigger, the reload winning when it coincides with a roll-over, and the full descent through the decrement-by-one tail to a dark pin. The bench also holds a cycle-by-cycle scoreboard of level and pin for the whole run.

// File: rtl/led_fade_pkg.sv
package led_fade_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_LOAD  = 2'd1,
    UPD_SCALE = 2'd2,
    UPD_STEP  = 2'd3
  } upd_e;
endpackage

// File: rtl/led_fade_sync.sv
module led_fade_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R4: a held input yields a single-cycle edge
  p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/led_fade_ticker.sv
module led_fade_ticker #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;

  // R8: a roll-over restarts the count at zero
  p_wrap_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/led_fade_level.sv
module led_fade_level
  import led_fade_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int FRAC_SH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] level_o
);
  localparam logic [CNT_W-1:0] FULL  = '1;
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(1) << FRAC_SH;

  logic [CNT_W-1:0] level_q, level_d;
  upd_e             upd;

  always_comb begin
    if (load_i)                 upd = UPD_LOAD;
    else if (!wrap_i)           upd = UPD_HOLD;
    else if (level_q >= FLOOR)  upd = UPD_SCALE;
    else if (level_q != '0)     upd = UPD_STEP;
    else                        upd = UPD_HOLD;
  end

  always_comb begin
    unique case (upd)
      UPD_LOAD:  level_d = FULL;
      UPD_SCALE: level_d = level_q - (level_q >> FRAC_SH);
      UPD_STEP:  level_d = level_q - 1'b1;
      default:   level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level_o = level_q;

  // R3 and R6: a reload always yields full scale, roll-over or not
  p_load_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (level_q == FULL));
  // R9: quiet between roll-overs
  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !wrap_i) |=> $stable(level_q));
  // R2: the fade never brightens by itself
  p_never_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (level_q <= $past(level_q)));
  // R5: every roll-over makes progress toward dark
  p_strict_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && wrap_i && level_q != '0) |=> (level_q < $past(level_q)));
endmodule

// File: rtl/led_fade_pwm.sv
module led_fade_pwm #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             led_o
);
  logic led_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= (level_i > cnt_i);
  end

  assign led_o = led_q;

  // R1: a dark level keeps the pin dark
  p_dark_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == '0) |=> !led_o);
  // R1: full level lights every slot but the last
  p_lit_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((&level_i) && !(&cnt_i)) |=> led_o);
endmodule

// File: rtl/led_fade_dimmer.sv
module led_fade_dimmer #(
  parameter int CNT_W   = 24,
  parameter int FRAC_SH = 5,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  output logic             led_o,
  output logic [CNT_W-1:0] level_o
);
  logic             trig_rise;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] level;

  led_fade_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(trig_i), .rise_o(trig_rise));

  led_fade_ticker #(.CNT_W(CNT_W)) u_ticker (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .wrap_o(wrap));

  led_fade_level #(.CNT_W(CNT_W), .FRAC_SH(FRAC_SH)) u_level (
    .clk(clk), .rst_n(rst_n), .load_i(trig_rise), .wrap_i(wrap),
    .level_o(level));

  led_fade_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .level_i(level), .cnt_i(cnt), .led_o(led_o));

  assign level_o = level;

  // R7: the first cycle out of reset is dark
  p_reset_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (level_o == '0 && !led_o));
endmodule

// File: tb/test_led_fade_dimmer.sv
module test_led_fade_dimmer;
  localparam int W    = 8;
  localparam int SH   = 5;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         trig_i = 1'b0;
  logic         led_o;
  logic [W-1:0] level_o;

  always #2.5 clk = ~clk;

  led_fade_dimmer #(.CNT_W(W), .FRAC_SH(SH)) i_led_fade_dimmer (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .led_o(led_o), .level_o(level_o));

  typedef struct {
    int    lvl;
    bit    led;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model of the requirements (R1 R2 R3 R5 R6 R8 R9)
  int m_cnt, m_lvl;
  bit m_s1, m_s2, m_s3, m_led;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_lvl = 0; m_led = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit    rise, wrap;
      int    nl;
      string tg;
      rise = m_s2 && !m_s3;
      wrap = (m_cnt == MAXV);
      m_led = (m_lvl > m_cnt);
      if (rise) begin nl = MAXV; tg = wrap ? "R6" : "R3"; end
      else if (wrap && m_lvl >= (1 << SH)) begin nl = m_lvl - (m_lvl >> SH); tg = "R2"; end
      else if (wrap && m_lvl != 0) begin nl = m_lvl - 1; tg = "R5"; end
      else begin nl = m_lvl; tg = "R9"; end
      m_lvl = nl;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_i;
      m_cnt = (m_cnt + 1) % (MAXV + 1);
      q.push_back('{lvl: nl, led: m_led, tag: tg});
    end
  end

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(int'(level_o) == e.lvl, e.tag, "scoreboard level", int'(level_o), e.lvl);
      chk(led_o == e.led, "R1", "scoreboard led", int'(led_o), int'(e.led));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int lit;
    int guard;
    repeat (4) @(negedge clk);
    chk(level_o == 0, "R7", "level in reset", int'(level_o), 0);
    chk(led_o == 0, "R7", "led in reset", int'(led_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(level_o == 0, "R7", "level after reset", int'(level_o), 0);
    // R1: zero level gives a dark pin for a whole period
    lit = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); lit += int'(led_o); end
    chk(lit == 0, "R1", "lit cycles at zero level", lit, 0);

    // R3: reload latency of three edges
    trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(int'(level_o) == MAXV, "R3", "level after trigger", int'(level_o), MAXV);

    // R2 and R8: first roll-over step from full scale
    guard = 0;
    while (int'(level_o) == MAXV && guard < 1000) begin @(negedge clk); guard++; end
    chk(int'(level_o) == 248, "R2", "first decay step", int'(level_o), 248);
    chk(guard <= 256, "R8", "cycles to first roll-over", guard, 256);

    // R4: long trigger reloads once, fade continues while held
    trig_i = 1'b1;
    repeat (1200) @(negedge clk);
    chk(int'(level_o) < MAXV, "R4", "level under held trigger below full", int'(level_o), MAXV - 1);
    chk(int'(level_o) > 0, "R4", "level under held trigger non-zero", int'(level_o), 1);
    trig_i = 1'b0;
    repeat (10) @(negedge clk);

    // R6: trigger edge coinciding with a roll-over
    guard = 0;
    while (m_cnt != 253 && guard < 1000) begin @(negedge clk); guard++; end
    trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(int'(level_o) == MAXV, "R6", "reload wins over roll-over", int'(level_o), MAXV);

    // R5: full descent to dark
    guard = 0;
    while (level_o != 0 && guard < 60000) begin @(negedge clk); guard++; end
    chk(level_o == 0, "R5", "level reaches zero", int'(level_o), 0);
    lit = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); lit += int'(led_o); end
    chk(lit == 0, "R5", "pin dark after fade", lit, 0);
    chk(level_o == 0, "R5", "level stays zero", int'(level_o), 0);
    finish_run();
  end
endmodule